// File: doc/BRIEF.md
# Pin Bank Controller with Edge Interrupts

This block is a general-purpose pin bank of up to 32 pins, reached through a small word-addressed register bus. Software sets a direction per pin, the value driven on output pins, and an open-drain option that turns a driven 1 into a released pin. Input levels pass through a flop synchronizer before they can be read or used for edge detection.

Each pin has a sense selection that decides which transitions of its synchronized level count as events. Events are latched in a sticky register and cleared by writing ones. A mask register picks which latched events reach the single combined interrupt line. A parameter selects the sense layout. In the narrow layout one control bit per pin chooses falling-only or both edges. In the wide layout two-bit fields spread over two control registers choose any-edge, rising, falling or off, and the top four pins become input-only.

Register bits are numbered from the pin side: pin p lives in register bit 31 − p, so pin 0 is the most significant bit of every register.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is all zeros and `irq` is 0.
- R2: The register index is `bus_addr[4:2]`: 0 direction, 1 open-drain, 2 data, 3 event, 4 mask, 5 sense control A, 6 sense control B. Pin p occupies bit 31 − p of each register, and `pin_in`/`pin_out`/`pin_oe` are indexed by pin number.
- R3: Index 7 reads 0 and ignores writes. In the narrow layout, index 6 is also unmapped: it reads 0 and ignores writes.
- R4: A direction bit of 1 makes the pin an output: `pin_oe[p]` is high and `pin_out[p]` equals its data bit from the clock edge that commits the write. A direction bit of 0 keeps `pin_oe[p]` low.
- R5: For an output pin whose open-drain bit is 1, `pin_oe[p]` is high only while its data bit is 0.
- R6: A data read returns the stored data bit for output pins and the synchronized level for input pins. The synchronized level follows a change on `pin_in` after two rising clock edges.
- R7: A qualifying input transition sets its event bit at the third rising edge after the pin changes. The bit then stays set until software clears it.
- R8: Writing the event register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: When a new edge and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R10: `irq` is high exactly when some bit is set in both the event and mask registers. The path is combinational from those registers.
- R11: In the narrow layout, a control A bit of 1 makes the pin sense falling edges only, and 0 makes it sense both edges.
- R12: In the wide layout, pins 0–15 use control A and pins 16–31 use control B, with the field at bits [2·(15 − p mod 16) +: 2]. The field codes are 00 any edge, 01 rising, 10 falling and 11 no events.
- R13: In the wide layout, pins 28–31 are input-only: their direction bits read 0, ignore writes, and `pin_oe` stays low for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read (with bus_sel) |
| bus_addr | input | ADDR_W | Byte offset; bits [4:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| pin_in | input | NPINS | Pin levels, indexed by pin number |
| pin_out | output | NPINS | Driven values, indexed by pin number |
| pin_oe | output | NPINS | Output enables, indexed by pin number |
| irq | output | 1 | Combined interrupt |

## Verification
The following results appear right after the clock edge that commits a write: register contents, `pin_out`, `pin_oe` and `irq`. The bench samples them at the next falling edge. A data read of an input reflects a pin change after two rising edges, and an event bit rises after three. For every pin the bench samples one edge early and expects the old value, then samples at the due edge and expects the new one. The clear-collision case drives the clearing write so that it commits on exactly the edge where the detected transition is latched. A wide-layout instance and a narrow-layout instance share the bus and pins, so every sweep checks both sense decodings against values computed from pin number and field codes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int REG_W = 32;

   typedef enum logic [2:0] {
      RI_DIR  = 3'd0,
      RI_ODE  = 3'd1,
      RI_DAT  = 3'd2,
      RI_EVT  = 3'd3,
      RI_MSK  = 3'd4,
      RI_CTA  = 3'd5,
      RI_CTB  = 3'd6,
      RI_NONE = 3'd7
   } reg_idx_e;

   typedef enum logic [1:0] {
      SNS_ANY  = 2'b00,
      SNS_RISE = 2'b01,
      SNS_FALL = 2'b10,
      SNS_OFF  = 2'b11
   } sense_e;

   // register-order mask covering pins lo..hi (pin p -> bit REG_W-1-p)
   function automatic logic [REG_W-1:0] pin_range_mask(int lo, int hi);
      logic [REG_W-1:0] m;
      m = '0;
      for (int p = 0; p < REG_W; p++) begin
         if (p >= lo && p <= hi) m[REG_W-1-p] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_bank_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_bank_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_bank_sense.sv
module gpio_bank_sense
   import gpio_bank_pkg::*;
#(
   parameter int NPINS    = 32,
   parameter bit TWO_BIT  = 1'b0
) (
   input  logic [NPINS-1:0] lvl_now,
   input  logic [NPINS-1:0] lvl_prev,
   input  logic [REG_W-1:0] ctl_a,
   input  logic [REG_W-1:0] ctl_b,
   output logic [NPINS-1:0] hit
);

   if (NPINS < 1 || NPINS > REG_W) begin : g_bad_npins
      $error("gpio_bank_sense: NPINS out of range");
   end

   logic unused_ctl;
   assign unused_ctl = ^{ctl_a, ctl_b};

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic rise, fall;
      assign rise = lvl_now[p] & ~lvl_prev[p];
      assign fall = ~lvl_now[p] & lvl_prev[p];

      if (TWO_BIT) begin : g_wide
         localparam int SH = 2 * (15 - (p % 16));
         logic [1:0] fld;
         logic       h;
         if (p < 16) begin : g_lo
            assign fld = ctl_a[SH +: 2];
         end else begin : g_hi
            assign fld = ctl_b[SH +: 2];
         end
         always_comb begin
            case (sense_e'(fld))
               SNS_ANY:  h = rise | fall;
               SNS_RISE: h = rise;
               SNS_FALL: h = fall;
               default:  h = 1'b0;
            endcase
         end
         assign hit[p] = h;
      end else begin : g_narrow
         assign hit[p] = ctl_a[REG_W-1-p] ? fall : (rise | fall);
      end
   end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int NPINS        = 32,
   parameter bit SENSE_2BIT   = 1'b0,
   parameter int INONLY_FIRST = 28,
   parameter int SYNC_STAGES  = 2,
   parameter int ADDR_W       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);

   // ---------------- elaboration checks ----------------
   if (NPINS < 1 || NPINS > REG_W) begin : g_bad_npins
      $error("gpio_bank: NPINS must be 1..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpio_bank: ADDR_W must be at least 5");
   end
   if (INONLY_FIRST < 0) begin : g_bad_inonly
      $error("gpio_bank: INONLY_FIRST must not be negative");
   end

   localparam logic [REG_W-1:0] PIN_MASK    = pin_range_mask(0, NPINS-1);
   localparam logic [REG_W-1:0] INONLY_MASK =
      SENSE_2BIT ? pin_range_mask(INONLY_FIRST, NPINS-1) : '0;
   localparam logic [REG_W-1:0] DIR_WMASK   = PIN_MASK & ~INONLY_MASK;

   // ---------------- address decode ----------------
   logic     in_range;
   reg_idx_e sel_idx;
   logic     wr_en, ev_wr;
   logic     unused_addr_lo;

   assign unused_addr_lo = ^bus_addr[1:0];

   if (ADDR_W > 5) begin : g_hi_addr
      assign in_range = (bus_addr[ADDR_W-1:5] == '0);
   end else begin : g_no_hi_addr
      assign in_range = 1'b1;
   end

   always_comb begin
      sel_idx = RI_NONE;
      if (in_range) begin
         case (bus_addr[4:2])
            3'd0:    sel_idx = RI_DIR;
            3'd1:    sel_idx = RI_ODE;
            3'd2:    sel_idx = RI_DAT;
            3'd3:    sel_idx = RI_EVT;
            3'd4:    sel_idx = RI_MSK;
            3'd5:    sel_idx = RI_CTA;
            3'd6:    sel_idx = SENSE_2BIT ? RI_CTB : RI_NONE;
            default: sel_idx = RI_NONE;
         endcase
      end
   end

   assign wr_en = bus_sel & bus_wr;
   assign ev_wr = wr_en && (sel_idx == RI_EVT);

   // ---------------- input path ----------------
   logic [NPINS-1:0] lvl_now, lvl_prev, hit;
   logic [REG_W-1:0] sync_r, hit_r;

   gpio_bank_sync #(
      .WIDTH (NPINS),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (lvl_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= '0;
      else        lvl_prev <= lvl_now;
   end

   // ---------------- registers ----------------
   logic [REG_W-1:0] dir_q, ode_q, dat_q, evt_q, msk_q, cta_q, ctb_q;
   logic [REG_W-1:0] clr_vec, evt_d, rd_dat;

   gpio_bank_sense #(
      .NPINS  (NPINS),
      .TWO_BIT(SENSE_2BIT)
   ) u_sense (
      .lvl_now (lvl_now),
      .lvl_prev(lvl_prev),
      .ctl_a   (cta_q),
      .ctl_b   (ctb_q),
      .hit     (hit)
   );

   // pin-number order <-> register order (pin p at bit REG_W-1-p)
   for (genvar p = 0; p < NPINS; p++) begin : g_map
      localparam int B = REG_W - 1 - p;
      assign sync_r[B]  = lvl_now[p];
      assign hit_r[B]   = hit[p];
      assign pin_out[p] = dat_q[B];
      assign pin_oe[p]  = dir_q[B] & ~(ode_q[B] & dat_q[B]);
   end
   if (NPINS < REG_W) begin : g_pad
      assign sync_r[REG_W-NPINS-1:0] = '0;
      assign hit_r[REG_W-NPINS-1:0]  = '0;
   end

   assign clr_vec = ev_wr ? bus_wdata : '0;
   assign evt_d   = (evt_q & ~clr_vec) | hit_r;
   assign rd_dat  = (dat_q & dir_q) | (sync_r & ~dir_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         ode_q <= '0;
         dat_q <= '0;
         evt_q <= '0;
         msk_q <= '0;
         cta_q <= '0;
         ctb_q <= '0;
      end else begin
         evt_q <= evt_d;
         if (wr_en) begin
            case (sel_idx)
               RI_DIR:  dir_q <= bus_wdata & DIR_WMASK;
               RI_ODE:  ode_q <= bus_wdata & PIN_MASK;
               RI_DAT:  dat_q <= bus_wdata & PIN_MASK;
               RI_MSK:  msk_q <= bus_wdata & PIN_MASK;
               RI_CTA:  cta_q <= bus_wdata;
               RI_CTB:  ctb_q <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   // ---------------- read and interrupt ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         case (sel_idx)
            RI_DIR:  bus_rdata = dir_q;
            RI_ODE:  bus_rdata = ode_q;
            RI_DAT:  bus_rdata = rd_dat;
            RI_EVT:  bus_rdata = evt_q;
            RI_MSK:  bus_rdata = msk_q;
            RI_CTA:  bus_rdata = cta_q;
            RI_CTB:  bus_rdata = ctb_q;
            default: bus_rdata = '0;
         endcase
      end
   end

   assign irq = |(evt_q & msk_q);

   // ---------------- assertions ----------------
   // R7
   ev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_wr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

   // R8
   ev_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_wr |=> ((evt_q & $past(bus_wdata & ~hit_r)) == '0));

   // R9
   ev_edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & $past(hit_r)) == $past(hit_r)));

   // R10
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_q == '0) |-> !irq);

   if (SENSE_2BIT) begin : g_chk_wide
      // R13
      inonly_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dir_q & INONLY_MASK) == '0);
   end else begin : g_chk_narrow
      // R11
      fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_r & sync_r & cta_q) == '0);
   end

endmodule

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] pin_in = '0;
   logic [31:0] rdata_a, rdata_b, out_a, out_b, oe_a, oe_b;
   logic        irq_a, irq_b;

   int nchk = 0;
   int errors = 0;

   always #2 clk = ~clk;

   gpio_bank #(.SENSE_2BIT(1'b0)) u_gpio_bank (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
      .pin_in(pin_in), .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a));

   gpio_bank #(.SENSE_2BIT(1'b1)) u_gpio_bank_w2 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
      .pin_in(pin_in), .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));

   localparam logic [4:0] A_DIR = 5'h00, A_ODE = 5'h04, A_DAT = 5'h08,
                          A_EVT = 5'h0C, A_MSK = 5'h10, A_CTA = 5'h14,
                          A_CTB = 5'h18, A_GAP = 5'h1C;

   function automatic logic [31:0] bitof(int p);
      return 32'h8000_0000 >> p;
   endfunction

   function automatic logic [31:0] rev32(logic [31:0] x);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = x[31-i];
      return r;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_sel = 1'b1; bus_wr = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      #1;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] ra, output logic [31:0] rb);
      @(negedge clk);
      bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
      #1;
      ra = rdata_a; rb = rdata_b;
      bus_sel = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, nchk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; nchk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] ra, rb, ea, eb, dirv, odev, datv;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 7; i++) begin
         rd(5'(i * 4), ra, rb);
         check("R1 reg A", ra, 32'h0);
         check("R1 reg B", rb, 32'h0);
      end
      check("R1 oe A", oe_a, 32'h0);
      check("R1 oe B", oe_b, 32'h0);
      check("R1 irq", {30'h0, irq_a, irq_b}, 32'h0);

      // R4 / R13 direction, walking one
      wr(A_DAT, 32'hFFFF_FFFF);
      for (int p = 0; p < 32; p++) begin
         wr(A_DIR, bitof(p));
         check("R4 oe walk A", oe_a, 32'h1 << p);
         check("R13 oe walk B", oe_b, (p < 28) ? (32'h1 << p) : 32'h0);
      end
      wr(A_DIR, 32'hFFFF_FFFF);
      rd(A_DIR, ra, rb);
      check("R2 dir read A", ra, 32'hFFFF_FFFF);
      check("R13 dir read B", rb, 32'hFFFF_FFF0);
      datv = 32'hA5C3_0F96;
      wr(A_DAT, datv);
      check("R4 pin_out A", out_a, rev32(datv));
      check("R4 pin_out B", out_b, rev32(datv));
      check("R4 oe all A", oe_a, 32'hFFFF_FFFF);
      check("R13 oe all B", oe_b, 32'h0FFF_FFFF);

      // R5 open drain
      odev = 32'hFF00_FF00; datv = 32'hF0F0_F0F0;
      wr(A_ODE, odev);
      wr(A_DAT, datv);
      rd(A_ODE, ra, rb);
      check("R2 ode read", ra, odev);
      check("R5 oe A", oe_a, rev32(~(odev & datv)));
      check("R5 oe B", oe_b, rev32(32'hFFFF_FFF0 & ~(odev & datv)));
      wr(A_DIR, 32'h0000_FFFF);
      check("R5 oe dir A", oe_a, rev32(32'h0000_FFFF & ~(odev & datv)));
      wr(A_ODE, 32'h0);

      // R6 data read mixes stored and synchronized values
      dirv = 32'hFFFF_0000; datv = 32'h1234_5678;
      wr(A_DIR, dirv);
      wr(A_DAT, datv);
      @(negedge clk) pin_in = 32'hCAFE_BABE;
      rd(A_DAT, ra, rb);
      check("R6 one edge A", ra, datv & dirv);
      check("R6 one edge B", rb, datv & dirv);
      rd(A_DAT, ra, rb);
      ea = (datv & dirv) | (rev32(32'hCAFE_BABE) & ~dirv);
      check("R6 two edges A", ra, ea);
      check("R6 two edges B", rb, ea);
      wr(A_DIR, 32'h0);
      wr(A_DAT, 32'h0);
      @(negedge clk) pin_in = '0;
      repeat (5) @(posedge clk);
      wr(A_EVT, 32'hFFFF_FFFF);

      // R7 R11 R12: narrow odd pins fall-only; wide 0-15 rising, 16-31 falling
      wr(A_CTA, 32'h5555_5555);
      wr(A_CTB, 32'hAAAA_AAAA);
      for (int p = 0; p < 32; p++) begin
         @(negedge clk) pin_in[p] = 1'b1;
         repeat (2) @(posedge clk);
         rd(A_EVT, ra, rb);
         check("R7 early A", ra, 32'h0);
         check("R7 early B", rb, 32'h0);
         rd(A_EVT, ra, rb);
         check("R11 rise A", ra, (p % 2 == 0) ? bitof(p) : 32'h0);
         check("R12 rise B", rb, (p < 16) ? bitof(p) : 32'h0);
         if (p == 0) begin
            repeat (5) @(posedge clk);
            rd(A_EVT, ra, rb);
            check("R7 sticky", ra, bitof(0));
         end
         wr(A_EVT, 32'hFFFF_FFFF);
         @(negedge clk) pin_in[p] = 1'b0;
         repeat (3) @(posedge clk);
         rd(A_EVT, ra, rb);
         check("R11 fall A", ra, bitof(p));
         check("R12 fall B", rb, (p >= 16) ? bitof(p) : 32'h0);
         wr(A_EVT, 32'hFFFF_FFFF);
      end

      // R11 R12: narrow all fall-only; wide code 11 on 0-15, code 00 on 16-31
      wr(A_CTA, 32'hFFFF_FFFF);
      wr(A_CTB, 32'h0);
      for (int p = 0; p < 32; p++) begin
         @(negedge clk) pin_in[p] = 1'b1;
         repeat (3) @(posedge clk);
         rd(A_EVT, ra, rb);
         check("R11 rise off A", ra, 32'h0);
         check("R12 off/any rise B", rb, (p >= 16) ? bitof(p) : 32'h0);
         wr(A_EVT, 32'hFFFF_FFFF);
         @(negedge clk) pin_in[p] = 1'b0;
         repeat (3) @(posedge clk);
         rd(A_EVT, ra, rb);
         check("R11 fall only A", ra, bitof(p));
         check("R12 off/any fall B", rb, (p >= 16) ? bitof(p) : 32'h0);
         wr(A_EVT, 32'hFFFF_FFFF);
      end

      // R10 / R8 interrupt, mask and partial clear
      wr(A_CTA, 32'h0);
      @(negedge clk) pin_in[5] = 1'b1;
      repeat (3) @(posedge clk);
      wr(A_MSK, bitof(6));
      check("R10 masked off", {30'h0, irq_a, irq_b}, 32'h0);
      wr(A_MSK, bitof(5) | bitof(6));
      check("R10 unmasked", {30'h0, irq_a, irq_b}, 32'h3);
      wr(A_EVT, bitof(6));
      rd(A_EVT, ra, rb);
      check("R8 clear other bit", ra, bitof(5));
      check("R10 still high", {31'h0, irq_a}, 32'h1);
      @(negedge clk) pin_in[9] = 1'b1;
      repeat (3) @(posedge clk);
      wr(A_EVT, bitof(5));
      rd(A_EVT, ra, rb);
      check("R8 partial clear A", ra, bitof(9));
      check("R8 partial clear B", rb, bitof(9));
      check("R10 low after clear", {30'h0, irq_a, irq_b}, 32'h0);
      wr(A_EVT, 32'h0);
      rd(A_EVT, ra, rb);
      check("R8 write zero", ra, bitof(9));
      @(negedge clk) pin_in = '0;
      repeat (4) @(posedge clk);
      wr(A_EVT, 32'hFFFF_FFFF);
      wr(A_MSK, 32'h0);

      // R9 edge and clear in the same cycle
      @(negedge clk) pin_in[20] = 1'b1;
      repeat (2) @(posedge clk);
      wr(A_EVT, 32'hFFFF_FFFF);
      rd(A_EVT, ra, rb);
      check("R9 edge wins A", ra, bitof(20));
      check("R9 edge wins B", rb, bitof(20));
      wr(A_EVT, 32'hFFFF_FFFF);
      rd(A_EVT, ra, rb);
      check("R8 cleared after collision", ra | rb, 32'h0);

      // R3 unmapped offsets
      wr(A_MSK, 32'h0F0F_0000);
      wr(A_GAP, 32'hFFFF_FFFF);
      rd(A_GAP, ra, rb);
      check("R3 gap A", ra, 32'h0);
      check("R3 gap B", rb, 32'h0);
      rd(A_MSK, ra, rb);
      check("R3 mask untouched", ra, 32'h0F0F_0000);
      wr(A_CTB, 32'hFFFF_FFFF);
      rd(A_CTB, ra, rb);
      check("R3 narrow ctlB unmapped", ra, 32'h0);
      check("R2 wide ctlB mapped", rb, 32'hFFFF_FFFF);

      summary();
      $finish;
   end

endmodule